// File: doc/BRIEF.md
# Configuration Register Attribute Engine

This block holds a small bank of configuration registers in which every bit has its own access rule. A bit is one of three kinds. Plain storage can be written by software. A status bit reads a hardware input. A constant bit always reads its fixed value. Storage bits can also carry modifiers. A sticky bit is reset only by the power-good reset and keeps its value through a warm reset. A key bit, while set, freezes every lock bit in the bank. A write-once bit takes a single software write and then holds its value until it is reset.

Software uses a plain register port. It drives a write enable, an address, write data and one enable per byte. Read data is a combinational function of the address, so it is valid in the same cycle. Writes take effect at the clock edge. The port has no handshake: every access completes in one cycle and is never held off, so there is no back-pressure to manage. The attributes are parameter masks, with one bit per register bit. Elaboration stops on an illegal mix: lock together with write-once, sticky on a read-only bit, or a bit that is both status and constant.

The default parameters describe four registers of 16 bits at addresses 0 to 3. Addresses 4 to 7 are unimplemented. The requirements below state the layout that follows from these defaults.

Top module: `cfgreg_attr_bank`

## Requirements
- R1: Address 0 bits [7:0] are plain read-write storage with reset value 0x11. A write to address 0 with both byte enables set makes the register read back the write data, and the read value follows the address in the same cycle.
- R2: Byte enable bit 0 gates bits [7:0] and byte enable bit 1 gates bits [15:8]. A byte whose enable is low keeps its old value.
- R3: Address 3 bits [7:0] always read hw_status bits [55:48], and software writes to them have no effect.
- R4: Address 3 bits [15:8] always read 0xC3, whatever is written and across both resets.
- R5: A warm reset (warm_rst_n low) returns the non-sticky storage bits to their reset values and leaves the sticky bits unchanged. The sticky bits are address 0 bits [15:8] (reset value 0x22) and address 2 bits [15:8].
- R6: A power-good reset (por_n low) returns every storage bit, sticky bits included, to its reset value.
- R7: Address 1 bit 8 is a key bit with reset value 0. Address 1 bits [7:0] are lock bits with reset value 0. While the stored key is 1, writes to the lock bits are ignored; while it is 0, they are accepted. The key itself and address 1 bits [15:9] are plain read-write.
- R8: In a write that changes both the key and the lock bits, the lock bits are judged against the key value stored before that write.
- R9: Address 2 bits [15:0] are write-once with reset value 0. The first write to a byte with its enable high is taken, and every later write to that byte is ignored.
- R10: A write whose byte enable is low for a write-once byte does not use up that byte's single write.
- R11: A warm reset re-arms the non-sticky write-once byte (address 2 bits [7:0]). The sticky write-once byte (address 2 bits [15:8]) keeps its value and stays consumed until a power-good reset, which re-arms both bytes.
- R12: Addresses 4 to 7 read as zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-good reset, asynchronous, active low; resets every bit |
| warm_rst_n | input | 1 | Warm reset, asynchronous, active low; spares sticky bits |
| wr_en | input | 1 | Write strobe for the current address |
| addr | input | AW (3) | Register address for both read and write |
| wdata | input | DW (16) | Write data |
| wr_be | input | DW/8 (2) | Per-byte write enables |
| hw_status | input | NREG*DW (64) | Hardware values for status bits, register r at bits [r*DW +: DW] |
| rd_data | output | DW (16) | Read value of the addressed register |

## Verification
The lock check and a key update can fall in the same cycle when one write to address 1 carries both a new key and new lock data. The bench provokes this twice. First the key is cleared while the lock byte is rewritten, and the lock byte must keep its old value. Then the key is set while the lock byte is rewritten, and the new lock data must land. The same kind of overlap happens at address 2, where one write can reach a byte already used and a byte still armed, or leave one byte disabled. The read after each write judges the bytes separately.

// File: rtl/cfgreg_pkg.sv
package cfgreg_pkg;

  typedef enum logic [1:0] {
    BIT_STORE = 2'd0,
    BIT_HW    = 2'd1,
    BIT_CONST = 2'd2
  } bit_kind_e;

  function automatic bit_kind_e kind_of(input logic is_hw, input logic is_const);
    if (is_hw)    return BIT_HW;
    if (is_const) return BIT_CONST;
    return BIT_STORE;
  endfunction

endpackage

// File: rtl/cfgreg_bit.sv
module cfgreg_bit
  import cfgreg_pkg::*;
#(
  parameter bit_kind_e KIND    = BIT_STORE,
  parameter bit        STICKY  = 1'b0,
  parameter bit        LOCKED  = 1'b0,
  parameter bit        ONCE    = 1'b0,
  parameter bit        RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic por_n,
  input  logic rst_any_n,
  input  logic wr_strobe,
  input  logic wdata_bit,
  input  logic lock_active,
  input  logic hw_in,
  output logic rd_bit,
  output logic used_o
);

  generate
    if (KIND == BIT_HW) begin : g_hw
      logic unused_hw;
      assign rd_bit    = hw_in;
      assign used_o    = 1'b0;
      assign unused_hw = ^{clk, por_n, rst_any_n, wr_strobe, wdata_bit, lock_active};
    end else if (KIND == BIT_CONST) begin : g_const
      logic unused_const;
      assign rd_bit       = RST_VAL;
      assign used_o       = 1'b0;
      assign unused_const = ^{clk, por_n, rst_any_n, wr_strobe, wdata_bit, lock_active, hw_in};
    end else begin : g_store
      logic bit_rst_n;
      logic used_q;
      logic take;
      logic store_q;
      logic unused_store;

      // sticky bits see only the power-good reset
      assign bit_rst_n    = STICKY ? por_n : rst_any_n;
      assign unused_store = hw_in;

      if (ONCE) begin : g_once
        always_ff @(posedge clk or negedge bit_rst_n) begin
          if (!bit_rst_n)     used_q <= 1'b0;
          else if (wr_strobe) used_q <= 1'b1;
        end
      end else begin : g_multi
        assign used_q = 1'b0;
      end

      assign take = wr_strobe & ~(LOCKED & lock_active) & ~used_q;

      always_ff @(posedge clk or negedge bit_rst_n) begin
        if (!bit_rst_n) store_q <= RST_VAL;
        else if (take)  store_q <= wdata_bit;
      end

      assign rd_bit = store_q;
      assign used_o = used_q;
    end
  endgenerate

endmodule

// File: rtl/cfgreg_word.sv
module cfgreg_word
  import cfgreg_pkg::*;
#(
  parameter int              DW         = 16,
  parameter int              BYTES      = DW / 8,
  parameter logic [DW-1:0]   RST_VAL    = '0,
  parameter logic [DW-1:0]   HW_MASK    = '0,
  parameter logic [DW-1:0]   CONST_MASK = '0,
  parameter logic [DW-1:0]   STICKY_MASK = '0,
  parameter logic [DW-1:0]   LOCK_MASK  = '0,
  parameter logic [DW-1:0]   ONCE_MASK  = '0
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             rst_any_n,
  input  logic [BYTES-1:0] byte_wr,
  input  logic [DW-1:0]    wdata,
  input  logic             lock_active,
  input  logic [DW-1:0]    hw_in,
  output logic [DW-1:0]    rd_word,
  output logic [DW-1:0]    used_word
);

  generate
    for (genvar i = 0; i < DW; i++) begin : g_bit
      cfgreg_bit #(
        .KIND   (kind_of(HW_MASK[i], CONST_MASK[i])),
        .STICKY (STICKY_MASK[i]),
        .LOCKED (LOCK_MASK[i]),
        .ONCE   (ONCE_MASK[i]),
        .RST_VAL(RST_VAL[i])
      ) u_bit (
        .clk        (clk),
        .por_n      (por_n),
        .rst_any_n  (rst_any_n),
        .wr_strobe  (byte_wr[i/8]),
        .wdata_bit  (wdata[i]),
        .lock_active(lock_active),
        .hw_in      (hw_in[i]),
        .rd_bit     (rd_word[i]),
        .used_o     (used_word[i])
      );
    end
  endgenerate

endmodule

// File: rtl/cfgreg_wr_decode.sv
module cfgreg_wr_decode #(
  parameter int NREG  = 4,
  parameter int AW    = 3,
  parameter int BYTES = 2
) (
  input  logic                    wr_en,
  input  logic [AW-1:0]           addr,
  input  logic [BYTES-1:0]        wr_be,
  output logic [NREG*BYTES-1:0]   byte_wr
);

  generate
    for (genvar r = 0; r < NREG; r++) begin : g_reg
      logic hit;
      assign hit = wr_en & (addr == AW'(r));
      for (genvar b = 0; b < BYTES; b++) begin : g_byte
        assign byte_wr[r*BYTES + b] = hit & wr_be[b];
      end
    end
  endgenerate

endmodule

// File: rtl/cfgreg_lock_ctl.sv
module cfgreg_lock_ctl #(
  parameter int               TOTAL    = 64,
  parameter logic [TOTAL-1:0] KEY_MASK = '0
) (
  input  logic [TOTAL-1:0] store_flat,
  output logic             lock_active
);

  // stored key bits only: a key written this cycle governs from the next one
  assign lock_active = |(store_flat & KEY_MASK);

endmodule

// File: rtl/cfgreg_rd_mux.sv
module cfgreg_rd_mux #(
  parameter int NREG = 4,
  parameter int DW   = 16,
  parameter int AW   = 3
) (
  input  logic [NREG*DW-1:0] rd_flat,
  input  logic [AW-1:0]      addr,
  output logic [DW-1:0]      rd_data
);

  always_comb begin
    rd_data = '0;
    for (int r = 0; r < NREG; r++) begin
      if (addr == AW'(r)) rd_data = rd_flat[r*DW +: DW];
    end
  end

endmodule

// File: rtl/cfgreg_attr_bank.sv
module cfgreg_attr_bank #(
  parameter int NREG  = 4,
  parameter int DW    = 16,
  parameter int AW    = 3,
  parameter logic [NREG*DW-1:0] RST_VAL     = 64'hC300_0000_0000_2211,
  parameter logic [NREG*DW-1:0] HW_MASK     = 64'h00FF_0000_0000_0000,
  parameter logic [NREG*DW-1:0] CONST_MASK  = 64'hFF00_0000_0000_0000,
  parameter logic [NREG*DW-1:0] STICKY_MASK = 64'h0000_FF00_0000_FF00,
  parameter logic [NREG*DW-1:0] KEY_MASK    = 64'h0000_0000_0100_0000,
  parameter logic [NREG*DW-1:0] LOCK_MASK   = 64'h0000_0000_00FF_0000,
  parameter logic [NREG*DW-1:0] ONCE_MASK   = 64'h0000_FFFF_0000_0000
) (
  input  logic                 clk,
  input  logic                 por_n,
  input  logic                 warm_rst_n,
  input  logic                 wr_en,
  input  logic [AW-1:0]        addr,
  input  logic [DW-1:0]        wdata,
  input  logic [DW/8-1:0]      wr_be,
  input  logic [NREG*DW-1:0]   hw_status,
  output logic [DW-1:0]        rd_data
);

  localparam int BYTES = DW / 8;
  localparam int TOTAL = NREG * DW;
  localparam logic [TOTAL-1:0] RO_MASK = HW_MASK | CONST_MASK;

  // illegal attribute mixes stop elaboration
  generate
    if ((DW % 8) != 0) begin : g_bad_width
      $error("register width must be a whole number of bytes");
    end
    if (NREG > (1 << AW)) begin : g_bad_addr
      $error("address too narrow for the register count");
    end
    if ((LOCK_MASK & ONCE_MASK) != '0) begin : g_bad_lock_once
      $error("a bit may not be both lock and write-once");
    end
    if ((STICKY_MASK & RO_MASK) != '0) begin : g_bad_sticky_ro
      $error("sticky does not apply to read-only bits");
    end
    if ((HW_MASK & CONST_MASK) != '0) begin : g_bad_hw_const
      $error("a bit may not be both status and constant");
    end
    if (((KEY_MASK | LOCK_MASK | ONCE_MASK) & RO_MASK) != '0) begin : g_bad_mod_ro
      $error("key, lock and write-once need storage bits");
    end
  endgenerate

  logic                    rst_any_n;
  logic [NREG*BYTES-1:0]   byte_wr;
  logic [TOTAL-1:0]        rd_flat;
  logic [TOTAL-1:0]        used_flat;
  logic                    lock_active;

  assign rst_any_n = por_n & warm_rst_n;

  cfgreg_wr_decode #(
    .NREG (NREG),
    .AW   (AW),
    .BYTES(BYTES)
  ) u_dec (
    .wr_en  (wr_en),
    .addr   (addr),
    .wr_be  (wr_be),
    .byte_wr(byte_wr)
  );

  cfgreg_lock_ctl #(
    .TOTAL   (TOTAL),
    .KEY_MASK(KEY_MASK)
  ) u_lock (
    .store_flat (rd_flat),
    .lock_active(lock_active)
  );

  generate
    for (genvar r = 0; r < NREG; r++) begin : g_reg
      cfgreg_word #(
        .DW         (DW),
        .BYTES      (BYTES),
        .RST_VAL    (RST_VAL[r*DW +: DW]),
        .HW_MASK    (HW_MASK[r*DW +: DW]),
        .CONST_MASK (CONST_MASK[r*DW +: DW]),
        .STICKY_MASK(STICKY_MASK[r*DW +: DW]),
        .LOCK_MASK  (LOCK_MASK[r*DW +: DW]),
        .ONCE_MASK  (ONCE_MASK[r*DW +: DW])
      ) u_word (
        .clk        (clk),
        .por_n      (por_n),
        .rst_any_n  (rst_any_n),
        .byte_wr    (byte_wr[r*BYTES +: BYTES]),
        .wdata      (wdata),
        .lock_active(lock_active),
        .hw_in      (hw_status[r*DW +: DW]),
        .rd_word    (rd_flat[r*DW +: DW]),
        .used_word  (used_flat[r*DW +: DW])
      );
    end
  endgenerate

  cfgreg_rd_mux #(
    .NREG(NREG),
    .DW  (DW),
    .AW  (AW)
  ) u_rd (
    .rd_flat(rd_flat),
    .addr   (addr),
    .rd_data(rd_data)
  );

endmodule

// File: rtl/cfgreg_attr_bank_chk.sv
module cfgreg_attr_bank_chk #(
  parameter int NREG = 4,
  parameter int DW   = 16,
  parameter int AW   = 3,
  parameter logic [NREG*DW-1:0] RST_VAL    = '0,
  parameter logic [NREG*DW-1:0] HW_MASK    = '0,
  parameter logic [NREG*DW-1:0] CONST_MASK = '0,
  parameter logic [NREG*DW-1:0] LOCK_MASK  = '0
) (
  input logic                clk,
  input logic                rst_any_n,
  input logic                wr_en,
  input logic [AW-1:0]       addr,
  input logic [DW-1:0]       rd_data,
  input logic [NREG*DW-1:0]  hw_status,
  input logic                lock_active,
  input logic [NREG*DW-1:0]  store_flat,
  input logic [NREG*DW-1:0]  used_flat
);

  localparam logic [AW:0] NREG_W = (AW+1)'(NREG);

  logic          mapped;
  logic [DW-1:0] cmask;
  logic [DW-1:0] cval;
  logic [DW-1:0] hmask;
  logic [DW-1:0] hval;

  always_comb begin
    cmask = '0;
    cval  = '0;
    hmask = '0;
    hval  = '0;
    for (int r = 0; r < NREG; r++) begin
      if (addr == AW'(r)) begin
        cmask = CONST_MASK[r*DW +: DW];
        cval  = RST_VAL[r*DW +: DW];
        hmask = HW_MASK[r*DW +: DW];
        hval  = hw_status[r*DW +: DW];
      end
    end
  end

  assign mapped = ({1'b0, addr} < NREG_W);

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_any_n)
    !mapped |-> rd_data == '0); // R12

  AST_UNMAPPED_NOWRITE: assert property (@(posedge clk) disable iff (!rst_any_n)
    (wr_en && !mapped) |=> ((store_flat ^ $past(store_flat)) & ~HW_MASK) == '0); // R12

  AST_CONST_FIXED: assert property (@(posedge clk) disable iff (!rst_any_n)
    mapped |-> (rd_data & cmask) == (cval & cmask)); // R4

  AST_HW_FOLLOW: assert property (@(posedge clk) disable iff (!rst_any_n)
    mapped |-> (rd_data & hmask) == (hval & hmask)); // R3

  AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_any_n)
    lock_active |=> ((store_flat ^ $past(store_flat)) & LOCK_MASK) == '0); // R7

  AST_ONCE_HOLD: assert property (@(posedge clk) disable iff (!rst_any_n)
    (|used_flat) |=> ((store_flat ^ $past(store_flat)) & $past(used_flat)) == '0); // R9

endmodule

bind cfgreg_attr_bank cfgreg_attr_bank_chk #(
  .NREG      (NREG),
  .DW        (DW),
  .AW        (AW),
  .RST_VAL   (RST_VAL),
  .HW_MASK   (HW_MASK),
  .CONST_MASK(CONST_MASK),
  .LOCK_MASK (LOCK_MASK)
) u_chk (
  .clk        (clk),
  .rst_any_n  (rst_any_n),
  .wr_en      (wr_en),
  .addr       (addr),
  .rd_data    (rd_data),
  .hw_status  (hw_status),
  .lock_active(lock_active),
  .store_flat (rd_flat),
  .used_flat  (used_flat)
);

// File: tb/cfgreg_attr_bank_bench.sv
module cfgreg_attr_bank_bench;

  localparam int PERIOD = 10;
  localparam int NV     = 37;

  // {write, req, addr, be, data, expected}
  localparam logic [41:0] VEC [0:NV-1] = '{
    {1'b0, 4'd1,  3'd0, 2'b00, 16'h0000, 16'h2211}, // R1 reset value
    {1'b0, 4'd4,  3'd3, 2'b00, 16'h0000, 16'hC3A5}, // R4 R3 reset view
    {1'b1, 4'd1,  3'd0, 2'b11, 16'hBEEF, 16'h0000},
    {1'b0, 4'd1,  3'd0, 2'b00, 16'h0000, 16'hBEEF}, // R1
    {1'b1, 4'd2,  3'd0, 2'b01, 16'h1234, 16'h0000},
    {1'b0, 4'd2,  3'd0, 2'b00, 16'h0000, 16'hBE34}, // R2 low byte only
    {1'b1, 4'd2,  3'd0, 2'b10, 16'h5600, 16'h0000},
    {1'b0, 4'd2,  3'd0, 2'b00, 16'h0000, 16'h5634}, // R2 high byte only
    {1'b1, 4'd3,  3'd3, 2'b11, 16'hFFFF, 16'h0000},
    {1'b0, 4'd3,  3'd3, 2'b00, 16'h0000, 16'hC3A5}, // R3 R4 write ignored
    {1'b1, 4'd7,  3'd1, 2'b11, 16'h00AB, 16'h0000},
    {1'b0, 4'd7,  3'd1, 2'b00, 16'h0000, 16'h00AB}, // R7 unlocked
    {1'b1, 4'd7,  3'd1, 2'b10, 16'h0100, 16'h0000},
    {1'b0, 4'd7,  3'd1, 2'b00, 16'h0000, 16'h01AB}, // R7 key set
    {1'b1, 4'd7,  3'd1, 2'b01, 16'h0055, 16'h0000},
    {1'b0, 4'd7,  3'd1, 2'b00, 16'h0000, 16'h01AB}, // R7 locked
    {1'b1, 4'd8,  3'd1, 2'b11, 16'h0000, 16'h0000},
    {1'b0, 4'd8,  3'd1, 2'b00, 16'h0000, 16'h00AB}, // R8 clear key, lock held
    {1'b1, 4'd8,  3'd1, 2'b11, 16'h01CD, 16'h0000},
    {1'b0, 4'd8,  3'd1, 2'b00, 16'h0000, 16'h01CD}, // R8 set key, lock taken
    {1'b1, 4'd7,  3'd1, 2'b01, 16'h00EE, 16'h0000},
    {1'b0, 4'd7,  3'd1, 2'b00, 16'h0000, 16'h01CD}, // R7
    {1'b1, 4'd9,  3'd2, 2'b01, 16'h0077, 16'h0000},
    {1'b0, 4'd9,  3'd2, 2'b00, 16'h0000, 16'h0077}, // R9 first write
    {1'b1, 4'd9,  3'd2, 2'b01, 16'h0088, 16'h0000},
    {1'b0, 4'd9,  3'd2, 2'b00, 16'h0000, 16'h0077}, // R9 second ignored
    {1'b1, 4'd10, 3'd2, 2'b01, 16'h9900, 16'h0000},
    {1'b0, 4'd10, 3'd2, 2'b00, 16'h0000, 16'h0077}, // R10 high disabled
    {1'b1, 4'd10, 3'd2, 2'b10, 16'h9900, 16'h0000},
    {1'b0, 4'd10, 3'd2, 2'b00, 16'h0000, 16'h9977}, // R10 still armed
    {1'b1, 4'd9,  3'd2, 2'b10, 16'h4400, 16'h0000},
    {1'b0, 4'd9,  3'd2, 2'b00, 16'h0000, 16'h9977}, // R9
    {1'b1, 4'd12, 3'd5, 2'b11, 16'hFFFF, 16'h0000},
    {1'b0, 4'd12, 3'd5, 2'b00, 16'h0000, 16'h0000}, // R12
    {1'b0, 4'd12, 3'd7, 2'b00, 16'h0000, 16'h0000}, // R12
    {1'b0, 4'd12, 3'd0, 2'b00, 16'h0000, 16'h5634}, // R12 no alias
    {1'b0, 4'd12, 3'd1, 2'b00, 16'h0000, 16'h01CD}  // R12 no alias
  };

  logic        clk = 1'b0;
  logic        por_n;
  logic        warm_rst_n;
  logic        wr_en;
  logic [2:0]  addr;
  logic [15:0] wdata;
  logic [1:0]  wr_be;
  logic [63:0] hw_status;
  logic [15:0] rd_data;

  int checks = 0;
  int fails  = 0;

  always #(PERIOD/2) clk = ~clk;

  cfgreg_attr_bank u_cfgreg_attr_bank (
    .clk       (clk),
    .por_n     (por_n),
    .warm_rst_n(warm_rst_n),
    .wr_en     (wr_en),
    .addr      (addr),
    .wdata     (wdata),
    .wr_be     (wr_be),
    .hw_status (hw_status),
    .rd_data   (rd_data)
  );

  task automatic do_write(input logic [2:0] a, input logic [1:0] be, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    addr  = a;
    wr_be = be;
    wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    wr_be = 2'b00;
  endtask

  task automatic check(input int req, input logic [2:0] a, input logic [15:0] exp);
    @(negedge clk);
    wr_en = 1'b0;
    addr  = a;
    #1;
    checks++;
    if (rd_data !== exp) begin
      fails++;
      $display("FAIL R%0d addr %0d actual %h expected %h", req, a, rd_data, exp);
    end
  endtask

  task automatic set_hw(input logic [7:0] v);
    hw_status = {8'h00, v, 48'h0};
  endtask

  task automatic pulse_warm();
    @(negedge clk);
    warm_rst_n = 1'b0;
    @(negedge clk);
    warm_rst_n = 1'b1;
  endtask

  task automatic pulse_por();
    @(negedge clk);
    por_n = 1'b0;
    @(negedge clk);
    por_n = 1'b1;
  endtask

  initial begin
    por_n      = 1'b0;
    warm_rst_n = 1'b1;
    wr_en      = 1'b0;
    addr       = '0;
    wdata      = '0;
    wr_be      = '0;
    set_hw(8'hA5);
    repeat (3) @(negedge clk);
    por_n = 1'b1;

    // reset state of the remaining registers
    check(6, 3'd1, 16'h0000); // R6
    check(6, 3'd2, 16'h0000); // R6

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][41]) do_write(VEC[i][36:34], VEC[i][33:32], VEC[i][31:16]);
      else            check(int'(VEC[i][40:37]), VEC[i][36:34], VEC[i][15:0]);
    end

    // R3: status bits follow the input
    set_hw(8'h5C);
    check(3, 3'd3, 16'hC35C);

    // R5: warm reset spares sticky bytes
    pulse_warm();
    check(5, 3'd0, 16'h5611);
    check(5, 3'd1, 16'h0000);
    check(11, 3'd2, 16'h9900); // R11 sticky once byte kept
    check(4, 3'd3, 16'hC35C);

    // R11: low once byte re-armed, high stays consumed
    do_write(3'd2, 2'b11, 16'h3333);
    check(11, 3'd2, 16'h9933);
    do_write(3'd2, 2'b01, 16'h4444);
    check(9, 3'd2, 16'h9933);

    // R7: key cleared by reset, lock byte writable
    do_write(3'd1, 2'b01, 16'h007E);
    check(7, 3'd1, 16'h007E);

    // R6: power-good reset restores everything
    pulse_por();
    check(6, 3'd0, 16'h2211);
    check(6, 3'd1, 16'h0000);
    check(6, 3'd2, 16'h0000);
    check(4, 3'd3, 16'hC35C);
    do_write(3'd2, 2'b11, 16'h4444);
    check(11, 3'd2, 16'h4444);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule